// File: doc/BRIEF.md
# Framed Serial Link Transmitter with Power Handshake

This block turns a 22-bit parallel word into a 25-bit serial frame and sends it one bit per fast-clock cycle, least significant slot first, so that one frame occupies 25 fast-clock cycles. Each frame has a forced-low lead bit, the 22 data bits in ascending order, and two trailing boundary bits. The boundary bits are the complement of the top data bit, so every frame contains at least one level change. The receiver uses those two bits to find the word boundary. The frame period is the pixel period, and the block takes a new word at each frame boundary.

The block also runs the link power sequence. A power-down request releases the line; it goes undriven, which also tells the far end to power down. When the request is released, the block sends a fixed number of idle frames before it accepts data. A receiver that loses the word boundary pulls the line high. While the line is driven, the block treats that as a request to back off: it releases the line for a fixed time (1.0 µs, counted in fast-clock cycles) and then repeats the whole warm-up.

Top module: `serlnk_top`

## Requirements
- R1: A frame is 25 slots sent back to back on `ser_o`. Slot 0 is always 0. Slots 1 to 22 carry data bits 0 to 21 in that order.
- R2: Slots 23 and 24 both carry the inverse of data bit 21.
- R3: While `drive_en_o` is high, frames follow one another with no gap, one slot per clock cycle.
- R4: The data word for a frame is sampled on the clock edge that ends slot 24 of the previous frame. Changes on `data_i` at any other time do not alter the frame being sent.
- R5: After synchronous reset, `drive_en_o`, `ready_o` and `ser_o` are 0. They stay 0 while `pd_req_i` is high.
- R6: `pd_req_i` high makes `drive_en_o` and `ready_o` low one clock later, from any state. `pd_req_i` low with the line released makes `drive_en_o` high one clock later, which starts a warm-up.
- R7: A warm-up sends exactly WARM_FRAMES idle frames (data all zero, slots 23 and 24 high) whatever `data_i` holds. `ready_o` is low during the warm-up and high from the first data frame onward.
- R8: A power-down request during a warm-up restarts the idle-frame count from zero on the next warm-up.
- R9: `line_hi_i` high while `drive_en_o` is high releases the line one clock later for exactly FAST_MHZ*BACKOFF_NS/1000 cycles (250 by default). After that a full warm-up begins.
- R10: `line_hi_i` has no effect while `pd_req_i` is high or while a back-off is in progress.
- R11: `ser_o` is 0 whenever `drive_en_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast serial clock, one slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| data_i | input | DATA_W | Parallel word for the next frame |
| pd_req_i | input | 1 | Power-down request, active high |
| line_hi_i | input | 1 | Line sensed pulled high by the far end |
| ser_o | output | 1 | Serial bit of the current slot |
| drive_en_o | output | 1 | Line driver enable; low means the line is released |
| ready_o | output | 1 | Data frames are being sent |

## Verification
The hardest case to reach from the ports is an interruption that lands in the middle of a frame or a sequence. Examples are a power-down during the idle frames, or a line-high pulse that is still held part-way through a back-off. A bench model that re-derives frame position only from `drive_en_o` could stay out of step with the design after such an event. The bench therefore restarts its slot and frame counters each time the line is released and throws away any pending expected words. The stimulus places a power-down inside the third idle frame and holds the line-high input for twenty cycles into the back-off. It then measures the released interval and checks the full warm-up again, idle frame by idle frame.

// File: rtl/serlnk_pkg.sv
package serlnk_pkg;

    localparam int DATA_W_DEF      = 22;
    localparam int WARM_FRAMES_DEF = 4096;
    localparam int FAST_MHZ_DEF    = 250;
    localparam int BACKOFF_NS_DEF  = 1000;

    typedef enum logic [1:0] {
        LNK_OFF  = 2'd0,
        LNK_WARM = 2'd1,
        LNK_RUN  = 2'd2,
        LNK_HOLD = 2'd3
    } lnk_state_e;

    // lead bit plus data plus a pair of boundary bits
    function automatic int frame_len(input int dw);
        return dw + 3;
    endfunction

    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/serlnk_ctrl.sv
module serlnk_ctrl
    import serlnk_pkg::*;
#(
    parameter int WARM_FRAMES = WARM_FRAMES_DEF,
    parameter int BACKOFF_CYC = 250
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pd_req_i,
    input  logic       line_hi_i,
    input  logic       frame_end_i,
    output lnk_state_e state_o,
    output logic       load_data_o
);

    localparam int WW = cnt_w(WARM_FRAMES);
    localparam int BW = cnt_w(BACKOFF_CYC);

    lnk_state_e      st_q, st_d;
    logic [WW-1:0]   warm_cnt_q;
    logic [BW-1:0]   hold_cnt_q;
    logic            warm_last, hold_last;

    assign warm_last = (warm_cnt_q == WW'(WARM_FRAMES - 1));
    assign hold_last = (hold_cnt_q == BW'(BACKOFF_CYC - 1));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LNK_OFF:  if (!pd_req_i) st_d = LNK_WARM;
            LNK_WARM: begin
                if (line_hi_i)                    st_d = LNK_HOLD;
                else if (frame_end_i && warm_last) st_d = LNK_RUN;
            end
            LNK_RUN:  if (line_hi_i) st_d = LNK_HOLD;
            LNK_HOLD: if (hold_last) st_d = LNK_WARM;
            default:  st_d = LNK_OFF;
        endcase
        if (pd_req_i) st_d = LNK_OFF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= LNK_OFF;
            warm_cnt_q <= '0;
            hold_cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q != LNK_WARM)  warm_cnt_q <= '0;
            else if (frame_end_i)  warm_cnt_q <= warm_cnt_q + 1'b1;
            if (st_q != LNK_HOLD)  hold_cnt_q <= '0;
            else                   hold_cnt_q <= hold_cnt_q + 1'b1;
        end
    end

    // the frame loaded at the next boundary carries data only from run onward
    assign load_data_o = (st_q == LNK_RUN) || ((st_q == LNK_WARM) && warm_last);
    assign state_o     = st_q;

    AST_PD_RELEASES: assert property (@(posedge clk) disable iff (rst)
        pd_req_i |=> (st_q == LNK_OFF)); // R6
    AST_LINE_BACKOFF: assert property (@(posedge clk) disable iff (rst)
        ((st_q == LNK_WARM || st_q == LNK_RUN) && line_hi_i && !pd_req_i) |=> (st_q == LNK_HOLD)); // R9
    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (st_q == LNK_HOLD && !hold_last && !pd_req_i) |=> (st_q == LNK_HOLD)); // R10
    AST_HOLD_EXIT: assert property (@(posedge clk) disable iff (rst)
        (st_q == LNK_HOLD && hold_last && !pd_req_i) |=> (st_q == LNK_WARM)); // R9
    AST_RUN_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        (st_q == LNK_RUN && $past(st_q) != LNK_RUN) |-> $past(frame_end_i)); // R7

endmodule

// File: rtl/serlnk_shift.sv
module serlnk_shift
    import serlnk_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active_i,
    input  logic              load_data_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              bit_o,
    output logic              frame_end_o
);

    localparam int FRAME_W = frame_len(DATA_W);
    localparam int SW      = cnt_w(FRAME_W);

    logic [FRAME_W-1:0] frm_q;
    logic [SW-1:0]      slot_q;

    function automatic logic [FRAME_W-1:0] pack(input logic [DATA_W-1:0] w);
        return {~w[DATA_W-1], ~w[DATA_W-1], w, 1'b0};
    endfunction

    assign frame_end_o = active_i && (slot_q == SW'(FRAME_W - 1));

    always_ff @(posedge clk) begin
        if (rst || !active_i) begin
            slot_q <= '0;
            frm_q  <= pack('0);
        end else if (frame_end_o) begin
            slot_q <= '0;
            frm_q  <= pack(load_data_i ? data_i : '0);
        end else begin
            slot_q <= slot_q + 1'b1;
            frm_q  <= frm_q >> 1;
        end
    end

    assign bit_o = frm_q[0];

    AST_GUARD_LEADS: assert property (@(posedge clk) disable iff (rst)
        (active_i && slot_q == '0) |-> !frm_q[0]); // R1
    AST_BOUNDARY_PAIR: assert property (@(posedge clk) disable iff (rst)
        (active_i && slot_q == '0) |-> (frm_q[FRAME_W-1] == frm_q[FRAME_W-2])); // R2
    AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (rst)
        slot_q < SW'(FRAME_W)); // R3
    AST_CAPTURE_WORD: assert property (@(posedge clk) disable iff (rst)
        (frame_end_o && load_data_i) |=> (!active_i || frm_q[DATA_W:1] == $past(data_i))); // R4

endmodule

// File: rtl/serlnk_top.sv
module serlnk_top
    import serlnk_pkg::*;
#(
    parameter int DATA_W      = DATA_W_DEF,
    parameter int WARM_FRAMES = WARM_FRAMES_DEF,
    parameter int FAST_MHZ    = FAST_MHZ_DEF,
    parameter int BACKOFF_NS  = BACKOFF_NS_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] data_i,
    input  logic              pd_req_i,
    input  logic              line_hi_i,
    output logic              ser_o,
    output logic              drive_en_o,
    output logic              ready_o
);

    localparam int BACKOFF_CYC = FAST_MHZ * BACKOFF_NS / 1000;

    lnk_state_e state;
    logic       load_data, frame_end, raw_bit, active;

    serlnk_ctrl #(
        .WARM_FRAMES (WARM_FRAMES),
        .BACKOFF_CYC (BACKOFF_CYC)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .pd_req_i    (pd_req_i),
        .line_hi_i   (line_hi_i),
        .frame_end_i (frame_end),
        .state_o     (state),
        .load_data_o (load_data)
    );

    assign active = (state == LNK_WARM) || (state == LNK_RUN);

    serlnk_shift #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk         (clk),
        .rst         (rst),
        .active_i    (active),
        .load_data_i (load_data),
        .data_i      (data_i),
        .bit_o       (raw_bit),
        .frame_end_o (frame_end)
    );

    assign drive_en_o = active;
    assign ready_o    = (state == LNK_RUN);
    assign ser_o      = active & raw_bit;

    AST_READY_AFTER_WARM: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> $past(drive_en_o)); // R7

endmodule

// File: tb/serlnk_top_tb.sv
module serlnk_top_tb;

    localparam int DW = 22;
    localparam int FW = DW + 3;
    localparam int WF = 8;
    localparam int BK = 250;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pd  = 1'b1;
    logic          lh  = 1'b0;
    logic [DW-1:0] din = '0;
    logic          ser, den, rdy;

    always #4 clk = ~clk;

    serlnk_top #(
        .DATA_W      (DW),
        .WARM_FRAMES (WF)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .data_i     (din),
        .pd_req_i   (pd),
        .line_hi_i  (lh),
        .ser_o      (ser),
        .drive_en_o (den),
        .ready_o    (rdy)
    );

    int            checks = 0;
    int            errors = 0;
    logic [FW-1:0] exp_q[$];
    logic [FW-1:0] cap;
    int            mslot = 0;
    int            mfidx = 0;
    int            last_idx = 0;
    int            data_frames = 0;
    int            kword = 0;
    bit            feed = 1'b0;
    event          fr_done;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] word(input int k);
        case (k)
            0:       return '0;
            1:       return '1;
            2:       return DW'(1) << (DW - 1);
            3:       return ~(DW'(1) << (DW - 1));
            default: return DW'((k * 32'h9E3779B1) ^ (k << 9));
        endcase
    endfunction

    // monitor: rebuilds frames from the line and compares against the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (den) begin
                chk(rdy == (mfidx >= WF), "R7 ready level", rdy, mfidx >= WF);
                cap[mslot] = ser;
                if (mslot == FW - 1) begin
                    logic [FW-1:0] e;
                    if (mfidx < WF) begin
                        e = {2'b11, {DW{1'b0}}, 1'b0};
                        chk(cap == e, "R7 idle frame", cap, e);
                    end else if (exp_q.size() == 0) begin
                        chk(1'b0, "R4 unexpected data frame", cap, 0);
                    end else begin
                        e = exp_q.pop_front();
                        data_frames++;
                        chk(cap == e, "R1 R2 R3 R4 data frame", cap, e);
                    end
                    last_idx = mfidx;
                    mfidx++;
                    mslot = 0;
                    -> fr_done;
                end else begin
                    mslot++;
                end
            end else begin
                chk(!ser && !rdy, "R11 released line quiet", {ser, rdy}, 0);
                mslot = 0;
                mfidx = 0;
                exp_q.delete();
            end
        end
    end

    // driver: presents a word at each frame boundary and pushes its expected frame
    initial begin
        forever begin
            @(fr_done);
            if (feed && last_idx >= WF - 1) begin
                logic [DW-1:0] w;
                w = word(kword);
                kword++;
                din = w;
                exp_q.push_back({~w[DW-1], ~w[DW-1], w, 1'b0});
                repeat (7) @(negedge clk);
                din = ~w; // R4: mid-frame change must not reach the line
            end else begin
                din = '1; // R7: idle frames ignore the data bus
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R3 actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int low;
        repeat (3) @(negedge clk);
        chk(!den && !rdy && !ser, "R5 reset outputs", {den, rdy, ser}, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(!den, "R5 held off by power-down", den, 0);

        lh  = 1'b1;
        din = '1;
        repeat (3) @(negedge clk);
        chk(!den, "R10 line-high ignored in power-down", den, 0);
        lh = 1'b0;
        pd = 1'b0;
        @(negedge clk);
        chk(den, "R6 R10 warm-up starts one clock after release", den, 1);

        // R8: interrupt inside the third idle frame
        repeat (60) @(negedge clk);
        pd = 1'b1;
        @(negedge clk);
        chk(!den && !rdy, "R6 R8 power-down mid warm-up", {den, rdy}, 0);
        repeat (3) @(negedge clk);
        pd   = 1'b0;
        feed = 1'b1;
        repeat (FW * (WF + 10)) @(negedge clk);
        chk(rdy, "R7 ready after warm-up", rdy, 1);
        chk(data_frames >= 8, "R4 data frames seen", data_frames, 8);

        // R9 back-off, with line-high held into the back-off (R10)
        lh = 1'b1;
        @(negedge clk);
        chk(!den, "R9 line-high releases line", den, 0);
        low = 1;
        do begin
            @(negedge clk);
            if (low == 20) lh = 1'b0;
            if (!den) low++;
        end while (!den && low < 1000);
        chk(low == BK, "R9 R10 back-off length", low, BK);

        repeat (FW * (WF + 6)) @(negedge clk);
        chk(rdy, "R9 data resumes after full warm-up", rdy, 1);
        chk(data_frames >= 14, "R9 data frames after back-off", data_frames, 14);

        pd = 1'b1;
        @(negedge clk);
        chk(!den && !rdy, "R6 power-down from run", {den, rdy}, 0);
        feed = 1'b0;
        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule